// File: doc/BRIEF.md
# Network Controller Reset Domain Controller

This block turns two reset sources into the individual reset enables of a network controller. The first source is an asynchronous active-low hardware reset pin. The second is a self-clearing software reset bit, which software sets by writing a one. Each source reaches its own set of destinations. The hardware pin resets every internal register domain and the bus configuration space. While the pin is low it also turns off the bus-side output drivers, reports the deep-reset power state and holds the PHY in reset. When the pin is released, the PHY reset is stretched by a fixed time and a one-cycle reload request goes to the nonvolatile-configuration reader. The software bit resets the internal domains only, for a fixed number of cycles. It leaves the bus side, configuration space and PHY alone.

Retention rules are applied here and not in each register file. The power-management enable and status bits are reset only by a hardware reset, and only when auxiliary power is absent. On the receive side, only the address-valid bit receives a clear. The address registers, multicast and VLAN filter tables, descriptor base registers, the transmit inter-packet-gap register and the packet buffer memory get no reset line at all, and their consumers keep their contents. The pin is synchronised by two flops. Assertion reaches the outputs at once, and release takes effect on the second rising edge.

Top module: `rstdom_ctrl`

## Requirements
- R1: While `rst_pin_n` is low, `bus_oe` is 0 and `pwr_deep` is 1, with no clock edge needed. Both keep these values until the second rising clock edge after the pin goes high. That edge turns `bus_oe` to 1 and `pwr_deep` to 0.
- R2: While the hardware reset is in effect (as defined in R1), all of `dom_rst`, `rx_vld_clr`, `wake_rst`, `cfg_rst` and `phy_rst` are 1. `dom_rst` has 7 bits: bit 0 general, 1 interrupt, 2 receive, 3 transmit, 4 statistics, 5 wakeup, 6 diagnostic. All of these except `phy_rst` drop to 0 together on the release edge.
- R3: `pme_rst` is 1 only while the hardware reset is in effect and `aux_pwr` is 0. It is 0 at all other times, including during a software reset.
- R4: `nvm_reload` is 1 for exactly the first cycle after the release edge. It is 0 at all other times.
- R5: `phy_rst` stays 1 for PHY_CYC = ceil(PHY_HOLD_NS / CLK_NS) cycles after the release edge, which is 40 at the defaults. It then drops to 0.
- R6: Outside hardware reset, a rising edge with `sw_rst_req` = 1 and no software pulse running starts a software pulse in the next cycle. For SW_PULSE cycles (8 at the defaults), `sw_rst_bit`, all `dom_rst` bits, `rx_vld_clr` and `wake_rst` are 1. After that, `sw_rst_bit` clears by itself.
- R7: During a software pulse, `cfg_rst`, `pme_rst`, `phy_rst`, `nvm_reload` and `pwr_deep` stay 0 and `bus_oe` stays 1.
- R8: A request sampled while a pulse runs, including on its last cycle, is ignored. A request held high therefore gives pulses of SW_PULSE cycles separated by exactly one idle cycle.
- R9: A falling `rst_pin_n` ends a running software pulse at once. Requests made during hardware reset are ignored, so `sw_rst_bit` is 0 after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_pin_n | input | 1 | Asynchronous hardware reset pin, active low |
| aux_pwr | input | 1 | Auxiliary power present |
| sw_rst_req | input | 1 | Write of one to the software reset bit |
| sw_rst_bit | output | 1 | Read value of the software reset bit |
| dom_rst | output | 7 | Per-domain reset enables |
| rx_vld_clr | output | 1 | Clear for the receive address valid bit |
| wake_rst | output | 1 | Reset of wake control (non-PME bits) and wake filter registers |
| pme_rst | output | 1 | Reset of the PME enable and PME status bits |
| cfg_rst | output | 1 | Bus configuration space reset |
| phy_rst | output | 1 | PHY reset |
| nvm_reload | output | 1 | One-cycle request to re-read the nonvolatile configuration |
| bus_oe | output | 1 | Bus-side output enable (0 means high impedance) |
| pwr_deep | output | 1 | Deep-reset power state indication |

## Verification
The assertions assume three things about the inputs:
- A low pulse on `rst_pin_n` covers at least one rising edge.
- `sw_rst_req` is synchronous to `clk`.
- `aux_pwr` is steady for the whole of a hardware reset.

The bench meets all three by changing every input only on falling edges and by holding the pin low for one or more full cycles. The cycle counters in the checker measure the PHY hold and the software pulse from the release or start edge. For that reason the checker stops checking while the pin is low, and a pin glitch between two edges is outside the stimulus.

// File: rtl/rstdom_pkg.sv
// Shared constants of the reset domain controller.
// Assumes: the domain order below is the bit order of dom_rst.
package rstdom_pkg;

    localparam int DOM_N = 7;

    typedef enum int {
        DOM_GENERAL = 0,
        DOM_IRQ     = 1,
        DOM_RX      = 2,
        DOM_TX      = 3,
        DOM_STATS   = 4,
        DOM_WAKE    = 5,
        DOM_DIAG    = 6
    } dom_idx_e;

    // Which domains each source reaches (1 = reset by that source).
    localparam logic [DOM_N-1:0] HW_REACH = '1;
    localparam logic [DOM_N-1:0] SW_REACH = '1;

endpackage

// File: rtl/rstdom_sync.sv
// Two-flop synchroniser for the hardware reset pin.
// Asserts asynchronously with the pin and releases on the second rising
// edge after the pin goes high. This is the only asynchronous logic here.
module rstdom_sync (
    input  logic clk,
    input  logic pin_n,
    output logic rst_s_n
);

    logic stage1;
    logic stage2;

    // Async clear from the pin, ones shifted in on release.
    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) begin
            stage1 <= 1'b0;
            stage2 <= 1'b0;
        end else begin
            stage1 <= 1'b1;
            stage2 <= stage1;
        end
    end

    assign rst_s_n = stage2;

endmodule

// File: rtl/rstdom_timer.sv
// Down-counting pulse timer.
// A start sampled while idle makes busy high for exactly LEN cycles.
// If start stays high, the count is reloaded on every edge, so busy stays
// high. A start sampled while busy is also a reload; callers that do not
// want that gate start with busy. Synchronous active-low reset.
module rstdom_timer #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int W = (LEN < 1) ? 1 : $clog2(LEN + 1);

    logic [W-1:0] cnt;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= W'(LEN);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/rstdom_fanout.sv
// Maps the two reset sources onto the per-domain and per-field enables.
// Applies the retention rules:
//   - PME bits are reset only by the hardware source, and only without
//     auxiliary power.
//   - Configuration space is reset only by the hardware source.
// Purely combinational.
module rstdom_fanout
    import rstdom_pkg::*;
(
    input  logic             hw_act,
    input  logic             sw_act,
    input  logic             aux_pwr,
    output logic [DOM_N-1:0] dom_rst,
    output logic             rx_vld_clr,
    output logic             wake_rst,
    output logic             pme_rst,
    output logic             cfg_rst
);

    // One enable per domain, gated by each source's reach mask.
    for (genvar i = 0; i < DOM_N; i++) begin : g_dom
        assign dom_rst[i] = (hw_act & HW_REACH[i]) | (sw_act & SW_REACH[i]);
    end

    // Field-level enables that follow their own retention rules.
    always_comb begin
        rx_vld_clr = dom_rst[DOM_RX];
        wake_rst   = dom_rst[DOM_WAKE];
        cfg_rst    = hw_act;
        pme_rst    = hw_act & ~aux_pwr;
    end

endmodule

// File: rtl/rstdom_ctrl.sv
// Reset domain controller, top level.
// Combines the synchronised hardware pin and the self-clearing software bit
// into the domain resets. It also produces the stretched PHY reset, the
// reload request and the bus and power-state indications.
// Assumes: sw_rst_req is synchronous to clk, and aux_pwr is steady during
// a hardware reset.
module rstdom_ctrl
    import rstdom_pkg::*;
#(
    parameter int CLK_NS      = 10,
    parameter int PHY_HOLD_NS = 400,
    parameter int SW_PULSE    = 8
) (
    input  logic             clk,
    input  logic             rst_pin_n,
    input  logic             aux_pwr,
    input  logic             sw_rst_req,
    output logic             sw_rst_bit,
    output logic [DOM_N-1:0] dom_rst,
    output logic             rx_vld_clr,
    output logic             wake_rst,
    output logic             pme_rst,
    output logic             cfg_rst,
    output logic             phy_rst,
    output logic             nvm_reload,
    output logic             bus_oe,
    output logic             pwr_deep
);

    localparam int PHY_CYC = (PHY_HOLD_NS + CLK_NS - 1) / CLK_NS;

    logic rst_s_n;
    logic hw_act;
    logic rel_q;
    logic phy_busy;
    logic sw_busy;
    logic sw_start;

    rstdom_sync u_sync (
        .clk     (clk),
        .pin_n   (rst_pin_n),
        .rst_s_n (rst_s_n)
    );

    assign hw_act = ~rst_s_n;

    // Delayed copy of the synchronised reset, used to find the release edge.
    always_ff @(posedge clk) begin
        if (!rst_s_n) rel_q <= 1'b0;
        else          rel_q <= 1'b1;
    end

    assign nvm_reload = rst_s_n & ~rel_q;

    // PHY hold: reloaded on every edge of hardware reset, then counts out
    // after the release.
    rstdom_timer #(.LEN(PHY_CYC)) u_phy_hold (
        .clk   (clk),
        .rst_n (1'b1),
        .start (hw_act),
        .busy  (phy_busy)
    );

    // Software pulse: starts only from idle, cleared by hardware reset.
    assign sw_start = sw_rst_req & ~sw_busy;

    rstdom_timer #(.LEN(SW_PULSE)) u_sw_pulse (
        .clk   (clk),
        .rst_n (rst_s_n),
        .start (sw_start),
        .busy  (sw_busy)
    );

    assign sw_rst_bit = sw_busy & rst_s_n;

    rstdom_fanout u_fanout (
        .hw_act     (hw_act),
        .sw_act     (sw_rst_bit),
        .aux_pwr    (aux_pwr),
        .dom_rst    (dom_rst),
        .rx_vld_clr (rx_vld_clr),
        .wake_rst   (wake_rst),
        .pme_rst    (pme_rst),
        .cfg_rst    (cfg_rst)
    );

    assign phy_rst  = hw_act | phy_busy;
    assign bus_oe   = rst_s_n;
    assign pwr_deep = hw_act;

endmodule

// File: rtl/rstdom_chk.sv
// Checker for rstdom_ctrl, attached with bind. It sees the top's ports only.
// Counters measure the PHY hold and the software pulse length.
module rstdom_chk #(
    parameter int CLK_NS      = 10,
    parameter int PHY_HOLD_NS = 400,
    parameter int SW_PULSE    = 8
) (
    input logic       clk,
    input logic       rst_pin_n,
    input logic       aux_pwr,
    input logic       sw_rst_bit,
    input logic [6:0] dom_rst,
    input logic       rx_vld_clr,
    input logic       wake_rst,
    input logic       pme_rst,
    input logic       cfg_rst,
    input logic       phy_rst,
    input logic       nvm_reload,
    input logic       bus_oe,
    input logic       pwr_deep
);

    localparam int PHY_CYC = (PHY_HOLD_NS + CLK_NS - 1) / CLK_NS;

    logic [15:0] up_cnt;
    logic [15:0] sw_len;

    // Cycles since the bus side came up, saturating.
    always_ff @(posedge clk) begin
        if (!bus_oe)                 up_cnt <= '0;
        else if (up_cnt != 16'hFFFF) up_cnt <= up_cnt + 16'd1;
    end

    // Length of the current software pulse.
    always_ff @(posedge clk) begin
        if (!sw_rst_bit) sw_len <= '0;
        else             sw_len <= sw_len + 16'd1;
    end

    // R1
    pin_low_state_chk: assert property (@(posedge clk) disable iff (rst_pin_n)
        (!bus_oe && pwr_deep && cfg_rst && phy_rst));

    // R3
    pme_in_reset_chk: assert property (@(posedge clk) disable iff (rst_pin_n)
        (pme_rst == !aux_pwr));

    // R3
    pme_idle_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        bus_oe |-> !pme_rst);

    // R4
    reload_single_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        nvm_reload |=> !nvm_reload);

    // R4
    reload_after_rel_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        nvm_reload |-> (bus_oe && !$past(bus_oe)));

    // R5
    phy_hold_len_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        $fell(phy_rst) |-> (int'(up_cnt) == PHY_CYC));

    // R6
    sw_len_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        ($fell(sw_rst_bit) && bus_oe) |-> (int'(sw_len) == SW_PULSE));

    // R6
    sw_reach_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        sw_rst_bit |-> ((&dom_rst) && rx_vld_clr && wake_rst));

    // R7
    sw_isolation_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (sw_rst_bit && bus_oe) |-> (!cfg_rst && !pme_rst && !nvm_reload && !pwr_deep));

endmodule

bind rstdom_ctrl rstdom_chk #(
    .CLK_NS      (CLK_NS),
    .PHY_HOLD_NS (PHY_HOLD_NS),
    .SW_PULSE    (SW_PULSE)
) u_chk (
    .clk        (clk),
    .rst_pin_n  (rst_pin_n),
    .aux_pwr    (aux_pwr),
    .sw_rst_bit (sw_rst_bit),
    .dom_rst    (dom_rst),
    .rx_vld_clr (rx_vld_clr),
    .wake_rst   (wake_rst),
    .pme_rst    (pme_rst),
    .cfg_rst    (cfg_rst),
    .phy_rst    (phy_rst),
    .nvm_reload (nvm_reload),
    .bus_oe     (bus_oe),
    .pwr_deep   (pwr_deep)
);

// File: tb/tb_rstdom_ctrl.sv
module tb_rstdom_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD_NS    = 400;
    localparam int SWP        = 8;
    localparam int PHYC       = (HOLD_NS + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int WD_LIMIT   = 100000;

    logic       clk = 1'b0;
    logic       rst_pin_n = 1'b0;
    logic       aux_pwr = 1'b0;
    logic       sw_rst_req = 1'b0;
    logic       sw_rst_bit;
    logic [6:0] dom_rst;
    logic       rx_vld_clr, wake_rst, pme_rst, cfg_rst, phy_rst;
    logic       nvm_reload, bus_oe, pwr_deep;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    rstdom_ctrl #(.CLK_NS(CLK_PERIOD), .PHY_HOLD_NS(HOLD_NS), .SW_PULSE(SWP)) dut (
        .clk(clk), .rst_pin_n(rst_pin_n), .aux_pwr(aux_pwr), .sw_rst_req(sw_rst_req),
        .sw_rst_bit(sw_rst_bit), .dom_rst(dom_rst), .rx_vld_clr(rx_vld_clr),
        .wake_rst(wake_rst), .pme_rst(pme_rst), .cfg_rst(cfg_rst), .phy_rst(phy_rst),
        .nvm_reload(nvm_reload), .bus_oe(bus_oe), .pwr_deep(pwr_deep)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_LIMIT) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act %0d cycles exp below %0d", cyc, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: act %0d exp %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Check every reset output against one expected state.
    task automatic chk_all(input string tag, input int e_hw, input int e_sw, input int e_phy,
                           input int e_nvm, input int e_aux);
        int e_any;
        e_any = (e_hw != 0 || e_sw != 0) ? 1 : 0;
        chk({tag, " bus_oe"},   int'(bus_oe),     e_hw ? 0 : 1);
        chk({tag, " pwr_deep"}, int'(pwr_deep),   e_hw);
        chk({tag, " dom_rst"},  int'(dom_rst),    e_any ? 127 : 0);
        chk({tag, " rx_vld"},   int'(rx_vld_clr), e_any);
        chk({tag, " wake"},     int'(wake_rst),   e_any);
        chk({tag, " cfg"},      int'(cfg_rst),    e_hw);
        chk({tag, " pme"},      int'(pme_rst),    (e_hw != 0 && e_aux == 0) ? 1 : 0);
        chk({tag, " phy"},      int'(phy_rst),    e_phy);
        chk({tag, " nvm"},      int'(nvm_reload), e_nvm);
        chk({tag, " swbit"},    int'(sw_rst_bit), e_sw);
    endtask

    // Release the pin at a falling edge and sweep the sequence that follows.
    task automatic release_sweep(input int aux);
        @(negedge clk);
        rst_pin_n  = 1'b1;
        sw_rst_req = 1'b0;
        #1;
        chk_all("R1 pre-edge", 1, 0, 1, 0, aux);
        for (int j = 1; j <= PHYC + 6; j++) begin
            @(posedge clk);
            @(negedge clk);
            // j counts edges since release: domains free at j=2, PHY at j=2+PHYC
            chk_all((j < 2) ? "R1 R2 sync" : ((j == 2) ? "R4 R5 rel" : "R5 R9 hold"),
                    (j < 2) ? 1 : 0, 0, (j < 2 + PHYC) ? 1 : 0, (j == 2) ? 1 : 0, aux);
        end
    endtask

    initial begin
        // Reset state at time zero, no clock edge yet.
        #1;
        chk_all("R1 R2 R3 initial", 1, 0, 1, 0, 0);

        // R2 R3 R9: hardware reset for both aux values and two lengths,
        // with a software request held during it.
        for (int aux = 0; aux < 2; aux++) begin
            for (int len = 1; len <= 4; len += 3) begin
                @(negedge clk);
                aux_pwr   = aux[0];
                rst_pin_n = 1'b0;
                #1;
                chk_all("R1 R2 R3 pin low", 1, 0, 1, 0, aux);
                sw_rst_req = 1'b1;
                for (int k = 0; k < len; k++) begin
                    @(posedge clk);
                    @(negedge clk);
                    chk_all("R2 R3 R9 in reset", 1, 0, 1, 0, aux);
                end
                release_sweep(aux);
            end
        end

        // R6 R7 R8: software request held for H cycles from idle.
        for (int aux = 0; aux < 2; aux++) begin
            for (int h = 1; h <= 20; h++) begin
                @(negedge clk);
                aux_pwr    = aux[0];
                sw_rst_req = 1'b1;
                for (int j = 1; j <= h + 2 * (SWP + 1); j++) begin
                    int k;
                    int r;
                    int e;
                    @(posedge clk);
                    @(negedge clk);
                    if (j == h) sw_rst_req = 1'b0;
                    // pulse k starts on edge 1+k*(SWP+1) if the request is still high there
                    k = (j - 1) / (SWP + 1);
                    r = (j - 1) % (SWP + 1);
                    e = (r < SWP && 1 + k * (SWP + 1) <= h) ? 1 : 0;
                    chk_all("R6 R7 R8 sw", 0, e, 0, 0, aux);
                end
                for (int w = 0; w < SWP + 2; w++) @(negedge clk);
                chk_all("R6 idle", 0, 0, 0, 0, aux);
            end
        end

        // R9: a hardware reset cuts a running software pulse short.
        @(negedge clk);
        aux_pwr    = 1'b1;
        sw_rst_req = 1'b1;
        @(negedge clk);
        sw_rst_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 pulse running", int'(sw_rst_bit), 1);
        rst_pin_n = 1'b0;
        #1;
        chk_all("R9 abort", 1, 0, 1, 0, 1);
        @(negedge clk);
        release_sweep(1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule